// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Controller

This block turns the sampled levels of a small IO port into interrupt requests. Each pin has its own trigger settings:
- level or edge sensing;
- for edge sensing, one edge or both edges;
- a polarity bit that picks the rising edge or high level when set, and the falling edge or low level when clear.

Every qualifying event sets a sticky bit in a raw status word. A mask word selects which raw bits reach the single combined interrupt line. Software reads the masked view, services the source and clears the raw bits by writing ones to a clear address.

Edges are found by comparing each pin with a registered copy of its previous value. Only pins whose direction bit marks them as inputs can produce edge events. Level-sensed pins re-set their status bit on every cycle in which the level matches the polarity, so clearing such a bit has no lasting effect while the level persists.

The pin inputs are expected to be synchronized already. The register port is a plain single-cycle write strobe with a combinational read. The port has no stream traffic, so it has no valid/ready handshake and no back-pressure.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset, the sense, both-edge, polarity and mask words and the raw status are all zero, every readable address returns 0, and `irq` is low.
- R2: On an edge-sensed pin (sense bit 0) whose both-edge bit is 0, a 0-to-1 change sets its raw bit when its polarity bit is 1. A 1-to-0 change sets it when its polarity bit is 0. A change in the other direction sets nothing.
- R3: On an edge-sensed pin whose both-edge bit is 1, any change of value sets its raw bit, whatever its polarity bit.
- R4: A pin whose `pin_dir` bit is 1 (output) produces no edge event, whatever its changes.
- R5: On a level-sensed pin (sense bit 1), the raw bit is set in every cycle in which the pin equals its polarity bit. It therefore stays set through a clear while that level persists, and it can be cleared once the level is gone.
- R6: A write to address 6 clears exactly those raw bits whose write-data bit is 1 and leaves the other raw bits unchanged.
- R7: When an event and a clear hit the same raw bit in the same cycle, the bit ends up set.
- R8: Address 5 reads raw AND mask, and `irq` is high exactly when that value is non-zero.
- R9: The address map is as follows. Addresses 0 (sense), 1 (both-edge), 2 (polarity) and 3 (mask) read back the last written value. Address 4 reads the raw status. Address 6 (clear) and address 7 read 0. Writes to addresses 4, 5 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Synchronized pin levels |
| pin_dir | input | NPINS | Per-pin direction, 1 = output |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Combinational read data for `reg_addr` |
| irq | output | 1 | Combined masked interrupt request |

## Verification
A wrong previous-value register or a wrong polarity term shows up as a raw status bit that is missing or unexpected. It appears on the read port one clock after the pin change that should or should not have triggered it. A broken clear or a lost set-wins rule shows at the read immediately after the clear write. A mask fault shows at once, as a mismatch between `irq`, the masked read and the raw read. The bench reads status after every stimulus step, so a wrong internal state is exposed within one or two clocks of its cause.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_SENSE = 3'd0,
    RA_BOTH  = 3'd1,
    RA_POL   = 3'd2,
    RA_MASK  = 3'd3,
    RA_RAW   = 3'd4,
    RA_MSKD  = 3'd5,
    RA_CLR   = 3'd6,
    RA_SPARE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pinirq_cfg.sv
module pinirq_cfg
  import pinirq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  sense,
  output logic [NPINS-1:0]  both,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  mask,
  output logic              clr_stb,
  output logic [NPINS-1:0]  clr_bits
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense <= '0;
      both  <= '0;
      pol   <= '0;
      mask  <= '0;
    end else if (wr) begin
      case (sel)
        RA_SENSE: sense <= wdata;
        RA_BOTH:  both  <= wdata;
        RA_POL:   pol   <= wdata;
        RA_MASK:  mask  <= wdata;
        default:  ;
      endcase
    end
  end

  assign clr_stb  = wr && (sel == RA_CLR);
  assign clr_bits = clr_stb ? wdata : '0;

  // R9: a write to the sense address is visible on the next cycle
  a_r9_sense_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_SENSE) |=> (sense == $past(wdata)));
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] pin_dir,
  input  logic [NPINS-1:0] sense,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] pol,
  output logic [NPINS-1:0] set_bits
);
  logic [NPINS-1:0] prev;

  // Tracks the pins continuously, also in reset, so the first cycle after reset sees no false edge.
  always_ff @(posedge clk) prev <= pin_in;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic changed, match, edge_hit, level_hit;
    assign changed   = pin_in[g] ^ prev[g];
    assign match     = ~(pin_in[g] ^ pol[g]);
    assign edge_hit  = ~sense[g] & ~pin_dir[g] & changed & (both[g] | match);
    assign level_hit = sense[g] & match;
    assign set_bits[g] = edge_hit | level_hit;
  end
endmodule

// File: rtl/pinirq_status.sv
module pinirq_status #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_bits,
  input  logic [NPINS-1:0] clr_bits,
  output logic [NPINS-1:0] raw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr_bits) | set_bits;
  end

  // R6: cleared bits with no concurrent event are zero next cycle
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(clr_bits & ~set_bits)) == '0));
  // R7: an event always lands, even against a clear
  a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(set_bits)) == $past(set_bits)));
  // R2: no raw bit appears without an event
  a_r2_no_spontaneous_bits: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw) & ~$past(set_bits)) == '0));
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  pin_dir,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic              irq
);
  logic [NPINS-1:0] sense, both, pol, mask, clr_bits, set_bits, raw, masked;
  logic             clr_stb;

  pinirq_cfg #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .sense(sense), .both(both), .pol(pol), .mask(mask),
    .clr_stb(clr_stb), .clr_bits(clr_bits)
  );

  pinirq_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .pin_in(pin_in), .pin_dir(pin_dir),
    .sense(sense), .both(both), .pol(pol), .set_bits(set_bits)
  );

  pinirq_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits), .raw(raw)
  );

  assign masked = raw & mask;
  assign irq    = |masked;

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_SENSE: reg_rdata = sense;
      RA_BOTH:  reg_rdata = both;
      RA_POL:   reg_rdata = pol;
      RA_MASK:  reg_rdata = mask;
      RA_RAW:   reg_rdata = raw;
      RA_MSKD:  reg_rdata = masked;
      default:  reg_rdata = '0;
    endcase
  end

  // R8: a zero mask keeps the line low
  a_r8_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  // R4: an output pin that is edge-sensed never contributes a new bit
  a_r4_output_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw) & $past(pin_dir & ~sense)) == '0));
  // R6: the clear strobe only carries data on the clear address
  a_r6_strobe_scope: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_stb) |-> (clr_bits == '0));
endmodule

// File: tb/test_pinirq_ctrl.sv
module test_pinirq_ctrl;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_dir = '0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]   a;
    logic [N-1:0] d;
    logic         q;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  pinirq_ctrl #(.NPINS(N)) i_pinirq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Monitor: compares outputs against the expected items at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (reg_rdata !== e.d || irq !== e.q) begin
        n_bad++;
        $display("FAIL %s addr=%0d rdata=%02h irq=%b expected rdata=%02h irq=%b",
                 e.tag, e.a, reg_rdata, irq, e.d, e.q);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [N-1:0] d, input logic q, input string tag);
    exp_t e;
    @(posedge clk); #1;
    reg_addr = a;
    e.a = a; e.d = d; e.q = q; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pins(input logic [N-1:0] v);
    @(posedge clk); #1;
    pin_in = v;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state on every address
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, 1'b0, "R1 reset");

    // R9: readback and ignored writes
    wr(3'd1, 8'h5A); rd(3'd1, 8'h5A, 1'b0, "R9 both readback");
    wr(3'd2, 8'h3C); rd(3'd2, 8'h3C, 1'b0, "R9 pol readback");
    wr(3'd3, 8'h81); rd(3'd3, 8'h81, 1'b0, "R9 mask readback");
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd4, 8'h00, 1'b0, "R9 raw unwritable");
    rd(3'd7, 8'h00, 1'b0, "R9 spare reads 0");
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R2: single-edge polarity
    wr(3'd2, 8'h01); wr(3'd3, 8'hFF);
    pins(8'h03); rd(3'd4, 8'h01, 1'b1, "R2 rising on pol=1 only");
    pins(8'h00); rd(3'd4, 8'h03, 1'b1, "R2 falling on pol=0");

    // R6: write-one-to-clear
    wr(3'd6, 8'h01); rd(3'd4, 8'h02, 1'b1, "R6 partial clear");
    wr(3'd6, 8'h02); rd(3'd4, 8'h00, 1'b0, "R6 full clear");
    rd(3'd6, 8'h00, 1'b0, "R9 clear reads 0");

    // R8: masking
    wr(3'd1, 8'h04);
    pins(8'h04); rd(3'd4, 8'h04, 1'b1, "R8 raw set");
    rd(3'd5, 8'h04, 1'b1, "R8 masked view");
    wr(3'd3, 8'h00);
    rd(3'd5, 8'h00, 1'b0, "R8 masked off");
    rd(3'd4, 8'h04, 1'b0, "R8 raw kept under mask");
    wr(3'd6, 8'hFF); wr(3'd3, 8'hFF);

    // R3: both edges
    pins(8'h00); rd(3'd4, 8'h04, 1'b1, "R3 falling");
    wr(3'd6, 8'h04);
    pins(8'h04); rd(3'd4, 8'h04, 1'b1, "R3 rising with pol=0");
    wr(3'd6, 8'h04);
    rd(3'd4, 8'h00, 1'b0, "R3 cleared");

    // R4: output pins ignored for edges
    @(posedge clk); #1 pin_dir = 8'h08;
    wr(3'd1, 8'h0C);
    pins(8'h0C); rd(3'd4, 8'h00, 1'b0, "R4 output rise ignored");
    pins(8'h04); rd(3'd4, 8'h00, 1'b0, "R4 output fall ignored");
    @(posedge clk); #1 pin_dir = 8'h00;
    pins(8'h0C); rd(3'd4, 8'h08, 1'b1, "R4 input edge counts");
    wr(3'd6, 8'hFF);

    // R5: level sensing, sticky while level persists
    wr(3'd2, 8'h10); wr(3'd0, 8'h10);
    rd(3'd4, 8'h00, 1'b0, "R5 level not matched");
    pins(8'h1C); rd(3'd4, 8'h10, 1'b1, "R5 level matched");
    wr(3'd6, 8'h10); rd(3'd4, 8'h10, 1'b1, "R5 clear overridden by level");
    pins(8'h0C); rd(3'd4, 8'h10, 1'b1, "R5 sticky after level drops");
    wr(3'd6, 8'h10); rd(3'd4, 8'h00, 1'b0, "R5 cleared after level gone");
    wr(3'd0, 8'h00);

    // R7: event and clear in the same cycle
    wr(3'd1, 8'h20);
    @(posedge clk); #1;
    pin_in = 8'h2C; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h20;
    @(posedge clk); #1 reg_wr = 1'b0;
    rd(3'd4, 8'h20, 1'b1, "R7 set wins over clear");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule